// File: doc/BRIEF.md
# Single-Precision Quiet Comparator with Denormal Tags

This block takes two IEEE-754 single-precision words, A and B, and reports how they are ordered. The 32-bit result word carries a one-hot relation field (less, equal, greater, unordered) in its low four bits. Two further bits mark whether A or B is a denormal. All other bits are zero. Next to the result it raises exception outputs that feed the status flag logic.

The compare is quiet. Any NaN makes the relation unordered. Only a signaling NaN raises the invalid exception. Denormal inputs are never flushed to zero, so they are ordered by their true magnitude. A parameter places an output register after the combinational compare. With the register, results appear one clock after the operands, and a synchronous active-high reset clears the register.

Top module: `fcmp_tag_unit`

## Requirements
- R1: Exactly one of result bits 3:0 is set. Bit 0 means A < B, bit 1 means A == B, bit 2 means A > B and bit 3 means unordered.
- R2: Result bit 4 is set when A is denormal and bit 5 when B is denormal. A denormal has a zero exponent field and a nonzero fraction. A zero is not tagged.
- R3: Denormals are not flushed. They are ordered by true value against zeros, against other denormals and against normals.
- R4: +0 and -0 compare equal.
- R5: A NaN in either operand gives unordered. A quiet NaN (exponent all ones, fraction bit 22 set) raises no exception.
- R6: A signaling NaN (exponent all ones, fraction nonzero with bit 22 clear) in either operand sets `exc_invalid` and `exc_summary`.
- R7: When no exception is raised, `exc_summary` and `exc_invalid` are 0, so a clean compare clears the summary flag left by an earlier one.
- R8: Infinities of the same sign compare equal, and -infinity is less than every other non-NaN value.
- R9: Result bits 31:6 are always zero.
- R10: With REG_OUT=1, outputs update one clock after the operands change. A synchronous reset drives the result and both exception outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | Operand A, single precision |
| op_b | input | 32 | Operand B, single precision |
| result | output | 32 | Relation one-hot in bits 3:0, denormal tags in bits 5:4 |
| exc_invalid | output | 1 | Invalid exception (signaling NaN seen) |
| exc_summary | output | 1 | Any exception raised by this compare |

## Verification
Denormal tagging and NaN handling can act in the same cycle. One operand can be a denormal while the other is a NaN. The result must then show both the unordered bit and that operand's tag, and the invalid exception follows the kind of NaN. Vectors pair a positive denormal with a signaling NaN, and a negative denormal with a quiet NaN. The full result word and both exception outputs are compared against values worked out by hand from the requirements.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = EXP_W + FRAC_W;
    localparam int REL_W  = 4;
    localparam int FIELD_W = REL_W + 2;
    localparam int TAG_A_BIT = REL_W;
    localparam int TAG_B_BIT = REL_W + 1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic zero;
        logic denorm;
        logic nan;
        logic snan;
    } fp_kind_t;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    function automatic logic [REL_W-1:0] rel_onehot(rel_e r);
        return REL_W'(1) << r;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  fp_word_t op,
    output fp_kind_t kind
);
    logic exp_max;
    logic exp_min;
    logic frac_nz;

    always_comb begin
        exp_max     = &op.exp;
        exp_min     = ~|op.exp;
        frac_nz     = |op.frac;
        kind.zero   = exp_min & ~frac_nz;
        kind.denorm = exp_min & frac_nz;
        kind.nan    = exp_max & frac_nz;
        kind.snan   = exp_max & frac_nz & ~op.frac[FRAC_W-1];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  fp_word_t a,
    input  fp_word_t b,
    input  logic     any_nan,
    input  logic     both_zero,
    output rel_e     rel
);
    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;

    always_comb begin
        mag_a = {a.exp, a.frac};
        mag_b = {b.exp, b.frac};
        if (any_nan)
            rel = REL_UN;
        else if (both_zero)
            rel = REL_EQ;
        else if (a.sign != b.sign)
            rel = a.sign ? REL_LT : REL_GT;
        else if (mag_a == mag_b)
            rel = REL_EQ;
        else if ((mag_a < mag_b) ^ a.sign)
            rel = REL_LT;
        else
            rel = REL_GT;
    end
endmodule

// File: rtl/fcmp_tag_unit.sv
module fcmp_tag_unit
    import fcmp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] result,
    output logic              exc_invalid,
    output logic              exc_summary
);
    fp_word_t ops  [2];
    fp_kind_t kinds[2];
    rel_e     rel;

    logic [WORD_W-1:0] res_c;
    logic              inv_c;
    logic              sum_c;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fcmp_classify u_cls (
            .op   (ops[i]),
            .kind (kinds[i])
        );
    end

    fcmp_order u_order (
        .a         (ops[0]),
        .b         (ops[1]),
        .any_nan   (kinds[0].nan | kinds[1].nan),
        .both_zero (kinds[0].zero & kinds[1].zero),
        .rel       (rel)
    );

    always_comb begin
        res_c                  = '0;
        res_c[REL_W-1:0]       = rel_onehot(rel);
        res_c[TAG_A_BIT]       = kinds[0].denorm;
        res_c[TAG_B_BIT]       = kinds[1].denorm;
        inv_c                  = kinds[0].snan | kinds[1].snan;
        sum_c                  = inv_c;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                result      <= '0;
                exc_invalid <= 1'b0;
                exc_summary <= 1'b0;
            end else begin
                result      <= res_c;
                exc_invalid <= inv_c;
                exc_summary <= sum_c;
            end
        end
    end else begin : g_comb
        assign result      = res_c;
        assign exc_invalid = inv_c;
        assign exc_summary = sum_c;
    end

    // R1
    a_r1_onehot_rel: assert property (@(posedge clk) disable iff (rst)
        $onehot(res_c[REL_W-1:0]));
    // R9
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        result[WORD_W-1:FIELD_W] == '0);
    // R5
    a_r5_nan_unordered: assert property (@(posedge clk) disable iff (rst)
        (kinds[0].nan || kinds[1].nan) |-> rel == REL_UN);
    // R4
    a_r4_zeros_equal: assert property (@(posedge clk) disable iff (rst)
        (kinds[0].zero && kinds[1].zero) |-> rel == REL_EQ);
    // R2
    a_r2_tag_not_zero: assert property (@(posedge clk) disable iff (rst)
        res_c[TAG_A_BIT] |-> (op_a[WORD_W-2:FRAC_W] == '0 && !kinds[0].zero));
    // R6
    a_r6_invalid_unordered: assert property (@(posedge clk) disable iff (rst)
        exc_invalid |-> result[REL_W-1]);
    // R7
    a_r7_summary_tracks: assert property (@(posedge clk) disable iff (rst)
        exc_summary == exc_invalid);
    // R8
    a_r8_neg_inf_low: assert property (@(posedge clk) disable iff (rst)
        (op_a == 32'hFF80_0000 && !kinds[1].nan && op_b != 32'hFF80_0000)
        |-> rel == REL_LT);
endmodule

// File: tb/fcmp_tag_unit_tb.sv
module fcmp_tag_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] result;
    logic        exc_invalid;
    logic        exc_summary;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fcmp_tag_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .op_a        (op_a),
        .op_b        (op_b),
        .result      (result),
        .exc_invalid (exc_invalid),
        .exc_summary (exc_summary)
    );

    // {a, b, result[5:0], invalid}; result bits: 5 tagB, 4 tagA, 3 un, 2 gt, 1 eq, 0 lt
    localparam int NV = 17;
    localparam logic [70:0] VEC [NV] = '{
        {32'h3F80_0000, 32'h4000_0000, 6'h01, 1'b0},
        {32'h4000_0000, 32'h3F80_0000, 6'h04, 1'b0},
        {32'h3F80_0000, 32'h3F80_0000, 6'h02, 1'b0},
        {32'hBF80_0000, 32'hC000_0000, 6'h04, 1'b0},
        {32'h0000_0000, 32'h8000_0000, 6'h02, 1'b0},
        {32'h0000_0001, 32'h0000_0000, 6'h14, 1'b0},
        {32'h0000_0001, 32'h0000_0002, 6'h31, 1'b0},
        {32'h8000_0001, 32'h0000_0001, 6'h31, 1'b0},
        {32'h7F80_0000, 32'h7F80_0000, 6'h02, 1'b0},
        {32'hFF80_0000, 32'hFF7F_FFFF, 6'h01, 1'b0},
        {32'hFF80_0000, 32'hFF80_0000, 6'h02, 1'b0},
        {32'h7FC0_0000, 32'h3F80_0000, 6'h08, 1'b0},
        {32'h7F80_0001, 32'h3F80_0000, 6'h08, 1'b1},
        {32'h0000_0005, 32'h7FA0_0000, 6'h18, 1'b1},
        {32'h807F_FFFF, 32'h7FC0_0000, 6'h18, 1'b0},
        {32'h0080_0000, 32'h007F_FFFF, 6'h24, 1'b0},
        {32'hFF80_0000, 32'h8000_0001, 6'h21, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R10 reset state with live operands
        op_a = 32'h7F80_0001;
        op_b = 32'h3F80_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset result", result, 32'h0);
        chk("R10 reset flags", {30'b0, exc_invalid, exc_summary}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][70:39], VEC[i][38:7]);
            chk("R1/R2/R3/R4/R8/R9 result", result, {26'b0, VEC[i][6:1]});
            chk("R5/R6/R7 flags", {30'b0, exc_invalid, exc_summary},
                {30'b0, VEC[i][0], VEC[i][0]});
        end

        // R7: clean compare after a signaling NaN clears summary
        apply(32'hFFA0_0000, 32'h0000_0000);
        chk("R6 invalid set", {31'b0, exc_summary}, 32'h1);
        apply(32'h0000_0000, 32'h3F80_0000);
        chk("R7 summary cleared", {30'b0, exc_invalid, exc_summary}, 32'h0);
        chk("R3 zero below normal", result, 32'h1);

        // R5: quiet NaN in B with denormal A: no exception
        apply(32'h0000_0003, 32'hFFC0_0001);
        chk("R5 quiet nan", {result[5:0], exc_invalid, exc_summary}, {6'h18, 2'b00});

        // R8: -inf below -0
        apply(32'hFF80_0000, 32'h8000_0000);
        chk("R8 neg inf below zero", result, 32'h1);

        // R10: output holds until the next clock edge
        apply(32'h3F80_0000, 32'h3F80_0000);
        @(negedge clk);
        op_a = 32'h3F80_0000;
        op_b = 32'h4000_0000;
        #1;
        chk("R10 held before edge", result, 32'h2);
        @(posedge clk);
        @(negedge clk);
        chk("R10 updated after edge", result, 32'h1);

        // R10: synchronous reset mid-run
        apply(32'h7F80_0001, 32'h0000_0001);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 mid-run reset", {result[29:0], exc_invalid, exc_summary}, 32'h0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R2 R6 after reset", {result[5:0], exc_invalid, exc_summary}, {24'b0, 6'h28, 2'b11});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule